// File: doc/BRIEF.md
# Precise Exception Cancellation Unit

This block sits beside the control path of an eight-stage in-order integer pipeline. Five of the stages can report faults, each with its own group of cause flags: the decode stage, the execute stage, the second data stage, the tag-check stage and the write-back stage. In every cycle the unit keeps only the flags of stages that hold a valid instruction. It picks the fault that belongs to the oldest instruction, which is the one furthest down the pipe. It then cancels that instruction and every younger one. Cancellation is a kill mask and a copy of the per-stage valid bits with the killed stages cleared.

One cycle after a fault is taken, the unit raises a single-cycle redirect pulse and presents a numeric cause code for the handler fetch logic. A frozen pipeline takes no fault. When the freeze lifts, a fault that is still flagged is taken, and it cancels younger instructions even if they were stalled and restarted for an unrelated interlock. A pending restart request is passed through only when no kill is issued in that cycle.

None of the pins carry a data stream. All inputs and outputs are plain level signals sampled on the rising clock edge, so there is no back-pressure.

Top module: `exc_cancel_unit`

## Requirements
- R1: During and right after reset, `redirect_o` is 0 and `cause_o` is 0.
- R2: When a fault is taken from stage s (stage index 0 is fetch, 7 is write-back), `kill_o` bits 0 through s are 1 and bits above s are 0. `valid_o` equals `stage_valid_i` with the killed bits cleared. When no fault is taken, `kill_o` is 0 and `valid_o` equals `stage_valid_i`.
- R3: When several stages flag together, the highest-indexed one wins, in the order write-back (7), tag check (6), second data (5), execute (3), decode (2).
- R4: Within a stage, the lowest-numbered flag bit wins. Cause codes are assigned as follows. Decode bit 0 gives code 1. Execute bits 0..7 give codes 2..9, in the order interrupt, instruction bus error, instruction coherency, illegal op, breakpoint, syscall, coprocessor unusable, instruction ECC. Second-data bits 0..2 give codes 10..12, in the order overflow, FP interrupt, trap. Tag-check bits 0..1 give codes 13..14, in the order data translation, TLB modified. Write-back bits 0..5 give codes 15..20, in the order reset, NMI, data bus error, watch, data coherency, data ECC.
- R5: `redirect_o` is 1 in the cycle after a take and only then. `cause_o` then shows the taken code and holds it until the next take.
- R6: Flags of a stage whose `stage_valid_i` bit is 0 have no effect on `kill_o`, `valid_o` or `redirect_o`.
- R7: While `stall_i` is 1, no fault is taken. A flag still present in the first cycle after the stall is released is taken.
- R8: In the cycle in which `redirect_o` is 1, all flags are ignored, so a flag held across two cycles produces exactly one redirect pulse.
- R9: `restart_go_o` equals `restart_pend_i` except in a cycle with a take, when it is 0.
- R10: A late overflow taken while a restart is pending cancels the restarted younger stages 0..5 and suppresses the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_valid_i | input | 8 | Valid bit per stage, index 0 = fetch, 7 = write-back |
| dec_flag_i | input | 1 | Decode-stage fault flags |
| exe_flag_i | input | 8 | Execute-stage fault flags |
| dat_flag_i | input | 3 | Second-data-stage fault flags |
| tag_flag_i | input | 2 | Tag-check-stage fault flags |
| wbk_flag_i | input | 6 | Write-back-stage fault flags |
| stall_i | input | 1 | Whole pipeline frozen this cycle |
| restart_pend_i | input | 1 | A restart request is pending |
| kill_o | output | 8 | Per-stage cancel mask |
| valid_o | output | 8 | Stage valid bits after cancellation |
| restart_go_o | output | 1 | Restart allowed this cycle |
| redirect_o | output | 1 | One-cycle handler redirect pulse |
| cause_o | output | 5 | Cause code of the most recent take |

## Verification
The properties assume that reset is asserted before the first edge and that flags, valid bits and stall are stable levels around each rising edge. They do not assume that a fault source drops its flag after the take, because the block itself masks the cycle that follows. The random stimulus draws every flag group, the valid bits, stall and the restart request independently each cycle. This produces overlaps that a real pipe would rarely show, such as faults in several stages at once, faults during a freeze, and a pending restart alongside a fault, while every input stays a legal static level. Directed cases pin down stage age order, in-stage priority, invalid stages, stall release, repeated flags and the late overflow during a restart.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG   = 8;
  localparam int DET_N  = 5;
  localparam int CODE_W = 5;

  // detecting stages, youngest first; index order sets age priority
  localparam int DET_STAGE [DET_N] = '{2, 3, 5, 6, 7};
  localparam int DET_W     [DET_N] = '{1, 8, 3, 2, 6};

  function automatic int det_off(input int j);
    int o;
    o = 0;
    for (int k = 0; k < j; k++) o += DET_W[k];
    return o;
  endfunction

  localparam int FLAG_W = det_off(DET_N);
endpackage

// File: rtl/exc_stage_enc.sv
module exc_stage_enc #(
  parameter int W      = 4,
  parameter int BASE   = 1,
  parameter int CODE_W = 5
) (
  input  logic              qual,
  input  logic [W-1:0]      flags,
  output logic              hit,
  output logic [CODE_W-1:0] code
);
  // lowest set bit carries the highest priority
  always_comb begin
    hit  = qual & (|flags);
    code = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (flags[i]) code = CODE_W'(BASE + i);
    end
  end
endmodule

// File: rtl/exc_age_sel.sv
module exc_age_sel
  import exc_pkg::*;
(
  input  logic [DET_N-1:0]             hit,
  input  logic [DET_N-1:0][CODE_W-1:0] codes,
  input  logic                         take_en,
  output logic                         take,
  output logic [NSTG-1:0]              kill,
  output logic [CODE_W-1:0]            code
);
  int oldest;

  always_comb begin
    oldest = -1;
    code   = '0;
    // later entries are older stages and overwrite younger ones
    for (int j = 0; j < DET_N; j++) begin
      if (hit[j]) begin
        oldest = DET_STAGE[j];
        code   = codes[j];
      end
    end
    take = (oldest >= 0) && take_en;
    for (int s = 0; s < NSTG; s++) begin
      kill[s] = take && (s <= oldest);
    end
  end
endmodule

// File: rtl/exc_cancel_unit.sv
module exc_cancel_unit
  import exc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSTG-1:0]       stage_valid_i,
  input  logic [DET_W[0]-1:0]   dec_flag_i,
  input  logic [DET_W[1]-1:0]   exe_flag_i,
  input  logic [DET_W[2]-1:0]   dat_flag_i,
  input  logic [DET_W[3]-1:0]   tag_flag_i,
  input  logic [DET_W[4]-1:0]   wbk_flag_i,
  input  logic                  stall_i,
  input  logic                  restart_pend_i,
  output logic [NSTG-1:0]       kill_o,
  output logic [NSTG-1:0]       valid_o,
  output logic                  restart_go_o,
  output logic                  redirect_o,
  output logic [CODE_W-1:0]     cause_o
);
  logic [FLAG_W-1:0]             all_flags;
  logic [DET_N-1:0]              det_hit;
  logic [DET_N-1:0][CODE_W-1:0]  det_code;
  logic                          take;
  logic [CODE_W-1:0]             sel_code;
  logic                          redirect_q;
  logic [CODE_W-1:0]             cause_q;

  assign all_flags = {wbk_flag_i, tag_flag_i, dat_flag_i, exe_flag_i, dec_flag_i};

  for (genvar j = 0; j < DET_N; j++) begin : g_det
    exc_stage_enc #(
      .W      (DET_W[j]),
      .BASE   (det_off(j) + 1),
      .CODE_W (CODE_W)
    ) u_enc (
      .qual  (stage_valid_i[DET_STAGE[j]]),
      .flags (all_flags[det_off(j) +: DET_W[j]]),
      .hit   (det_hit[j]),
      .code  (det_code[j])
    );

    AST_FLAGGED_STAGE_KILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_hit[j] && !stall_i && !redirect_q) |-> kill_o[DET_STAGE[j]]); // R2
  end

  exc_age_sel u_sel (
    .hit     (det_hit),
    .codes   (det_code),
    .take_en (!stall_i && !redirect_q),
    .take    (take),
    .kill    (kill_o),
    .code    (sel_code)
  );

  assign valid_o      = stage_valid_i & ~kill_o;
  assign restart_go_o = restart_pend_i & ~take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      cause_q    <= '0;
    end else begin
      redirect_q <= take;
      if (take) cause_q <= sel_code;
    end
  end

  assign redirect_o = redirect_q;
  assign cause_o    = cause_q;

  AST_REDIRECT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o); // R8
  AST_REDIRECT_AFTER_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill_o) |=> (redirect_o && cause_o != '0)); // R5
  AST_STALL_NO_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (kill_o == '0)); // R7
  AST_KILL_BLOCKS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill_o) |-> !restart_go_o); // R9
  AST_YOUNGEST_IN_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill_o) |-> kill_o[0]); // R2
  AST_CAUSE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o == '0) |=> $stable(cause_o)); // R5
endmodule

// File: tb/test_exc_cancel_unit.sv
`timescale 1ns/1ps
module test_exc_cancel_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sv;
  logic [0:0] fdec;
  logic [7:0] fexe;
  logic [2:0] fdat;
  logic [1:0] ftag;
  logic [5:0] fwbk;
  logic       stall, rpend;
  logic [7:0] kill, vout;
  logic       rgo, redir;
  logic [4:0] cause;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit exp_red = 0;
  int exp_cause = 0;

  always #2.5 clk = ~clk;

  exc_cancel_unit i_exc_cancel_unit (
    .clk_i(clk), .rst_ni(rst_n), .stage_valid_i(sv),
    .dec_flag_i(fdec), .exe_flag_i(fexe), .dat_flag_i(fdat),
    .tag_flag_i(ftag), .wbk_flag_i(fwbk), .stall_i(stall),
    .restart_pend_i(rpend), .kill_o(kill), .valid_o(vout),
    .restart_go_o(rgo), .redirect_o(redir), .cause_o(cause));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int low_bit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // reference: oldest valid flagged stage and its code (R3, R4, R6)
  function automatic void model(output int stg, output int code);
    stg = -1; code = 0;
    if (sv[7] && fwbk != 0)      begin stg = 7; code = 15 + low_bit({2'b0, fwbk}); end
    else if (sv[6] && ftag != 0) begin stg = 6; code = 13 + low_bit({6'b0, ftag}); end
    else if (sv[5] && fdat != 0) begin stg = 5; code = 10 + low_bit({5'b0, fdat}); end
    else if (sv[3] && fexe != 0) begin stg = 3; code = 2 + low_bit(fexe); end
    else if (sv[2] && fdec != 0) begin stg = 2; code = 1; end
  endfunction

  task automatic step(input string tag);
    int stg, code;
    bit take;
    logic [7:0] km;
    model(stg, code);
    take = (stg >= 0) && !stall && !exp_red;
    km = take ? 8'((9'd1 << (stg + 1)) - 9'd1) : 8'h00;
    #1;
    chk(kill == km, tag, "kill_o", kill, km);
    chk(vout == (sv & ~km), tag, "valid_o", vout, sv & ~km);
    chk(rgo == (rpend && !take), {tag, "/R9"}, "restart_go_o", rgo, rpend && !take);
    chk(redir == exp_red, {tag, "/R5"}, "redirect_o", redir, exp_red);
    chk(int'(cause) == exp_cause, {tag, "/R5"}, "cause_o", cause, exp_cause);
    @(posedge clk);
    exp_red = take;
    if (take) exp_cause = code;
    @(negedge clk);
  endtask

  task automatic idle();
    sv = 8'hFF; fdec = '0; fexe = '0; fdat = '0; ftag = '0; fwbk = '0;
    stall = 0; rpend = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(redir == 1'b0, "R1", "redirect_o", redir, 0);
    chk(cause == 5'd0, "R1", "cause_o", cause, 0);
    rst_n = 1'b1;
    step("R1");

    // R3: execute and write-back both flag; write-back wins, code 17
    idle(); fexe = 8'h01; fwbk = 6'b000100; step("R3");
    idle(); step("R3");
    chk(cause == 5'd17, "R3", "cause_o", cause, 17);

    // R4: in-stage priority, NMI over data errors (code 16)
    idle(); fwbk = 6'b110010; step("R4");
    idle(); step("R4");
    chk(cause == 5'd16, "R4", "cause_o", cause, 16);
    idle(); fexe = 8'b1010_0000; step("R4");
    idle(); step("R4");
    chk(cause == 5'd7, "R4", "cause_o", cause, 7);

    // R6: flag in an invalid stage has no effect
    idle(); sv = 8'hDF; fdat = 3'b001; step("R6");
    chk(redir == 1'b0, "R6", "redirect_o", redir, 0);

    // R7: stall holds off the take, release takes it
    idle(); stall = 1; ftag = 2'b10; step("R7");
    step("R7");
    stall = 0; step("R7");
    chk(cause == 5'd14, "R7", "cause_o", cause, 14);

    // R8: flag held two cycles gives one pulse
    idle(); fdec = 1'b1; step("R8");
    step("R8");
    idle(); step("R8");
    chk(redir == 1'b0, "R8", "redirect_o", redir, 0);

    // R10: late overflow while a restart is pending
    idle(); rpend = 1; fdat = 3'b001; step("R10");
    idle(); step("R10");
    chk(cause == 5'd10, "R10", "cause_o", cause, 10);

    // R2: random mix
    for (int n = 0; n < 400; n++) begin
      sv    = 8'($urandom) | 8'($urandom);
      fdec  = ($urandom % 8 == 0) ? 1'b1 : 1'b0;
      fexe  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      fdat  = ($urandom % 7 == 0) ? 3'($urandom) : 3'h0;
      ftag  = ($urandom % 8 == 0) ? 2'($urandom) : 2'h0;
      fwbk  = ($urandom % 9 == 0) ? 6'($urandom) : 6'h00;
      stall = ($urandom % 5 == 0);
      rpend = ($urandom % 4 == 0);
      step("R2");
    end
    finish_run();
  end
endmodule